// File: doc/BRIEF.md
# Floppy Controller Command Interface

This block is the host-facing command front end of a single-density floppy controller. The host writes a command word that holds a 3-bit function code together with a start bit. The block then runs that function as a short sequence of handshakes through one shared 8-bit buffer register. Addresses, sector data, status and error codes all pass through this register. A transfer-request flag tells the host when the next byte is expected or available. A done flag tells it when the command has finished. An error flag and an error-code register report why a command was refused.

A behavioural drive model is built into the block so that the sequencer can be checked without real media. The model holds one 128-byte sector image, a deleted-data mark for that image, and a write-protect switch for each of the two units. A 128-byte transfer buffer sits between the host and the drive model. The fill and empty functions load and unload it a byte at a time. A sector write copies it to the drive image, and a sector read copies the image back into it.

Top module: `fdc_cmd_if`

## Requirements
- R1: After reset, done is 1, transfer request is 0, the error flag is 0, the interrupt output is 0 and the buffer register reads 0.
- R2: Function 000 (fill) accepts 128 bytes written to the buffer, and function 001 (empty) presents the same 128 bytes in the same order, one per read strobe. Transfer request is 1 and done is 0 before every byte, and done returns after the 128th byte.
- R3: For functions 010 (write), 110 (write with deleted mark) and 011 (read), transfer request is raised first for the sector byte and then for the track byte. Done stays 0 until both bytes have been written.
- R4: A track value above 76 makes the command finish with the error flag (command bit 15) set and error code octal 040. The track check takes priority over the sector check.
- R5: A sector value of 0 or above 26 makes the command finish with the error flag set and error code octal 070.
- R6: A write to a unit whose write-protect input is 1 finishes with error code octal 100 and leaves the stored sector unchanged. Command bit 4 selects the unit, and wp[0] and wp[1] belong to units 0 and 1.
- R7: A sector read after a successful write returns, through an empty command, the bytes that were in the transfer buffer at the time of the write.
- R8: A read after a write with deleted mark sets status bit 6, and a read after a plain write clears it.
- R9: Function 101 loads the buffer with a status byte that has bit 7 = drive ready, bit 6 = deleted data, bit 2 = initialise done, and bits 1 and 0 = parity and CRC error, which are always 0. Function 111 loads the buffer with the stored error code.
- R10: Writing the command register with bit 14 set aborts any command in progress. It clears the error flag, the error code and the deleted mark at once. Done returns exactly INIT_CYCLES clock edges later, and the status byte then reads octal 204.
- R11: The unused function 100 completes with done and leaves both the buffer register and the stored error code unchanged.
- R12: A command-register write without bit 14 while done is 0 is ignored: the function field and the command in progress are unaffected.
- R13: The interrupt output equals interrupt enable (command bit 6) AND done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Write strobe for the command register |
| wr_buf | input | 1 | Write strobe for the buffer register |
| rd_buf | input | 1 | Read strobe that consumes one byte during an empty command |
| wdata | input | 16 | Write data; the buffer register takes bits 7..0 |
| wp | input | 2 | Write-protect switch of each simulated unit |
| cmd_rdata | output | 16 | Command register: error, transfer request, interrupt enable, done, unit, function |
| buf_rdata | output | 8 | Buffer register read value |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the track value across the limit at 76 and the sector value across 0 through 30. A design with an off-by-one compare would accept track 77 or sector 27, or refuse track 76 or sector 26. A track and a sector that are both bad must give the track code, so a design with the priority reversed reports octal 070. Write protection is checked per unit with only one switch set, which catches a design that decodes the unit bit wrongly. A protected write must also leave the stored image intact, so a design that copies before it checks shows the new data on the next read. The bench counts the cycles from initialise to done, which exposes an off-by-one init counter, and issues a start while a fill is in progress, which a design that re-arms when busy would accept.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    typedef enum logic [2:0] {
        FN_FILL   = 3'b000,
        FN_EMPTY  = 3'b001,
        FN_WRITE  = 3'b010,
        FN_READ   = 3'b011,
        FN_UNUSED = 3'b100,
        FN_STATUS = 3'b101,
        FN_WRDEL  = 3'b110,
        FN_ERRC   = 3'b111
    } fdc_fn_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_INIT, ST_SEC, ST_TRK, ST_EXEC, ST_FILL, ST_EMPTY
    } fdc_state_e;

    typedef struct packed {
        logic    ie;
        logic    unit;
        fdc_fn_e fn;
    } fdc_cmd_t;

    localparam logic [7:0] MAX_TRACK  = 8'd76;
    localparam logic [7:0] MAX_SECTOR = 8'd26;
    localparam logic [7:0] ERR_TRACK  = 8'o040;
    localparam logic [7:0] ERR_SECTOR = 8'o070;
    localparam logic [7:0] ERR_WPROT  = 8'o100;

    function automatic logic [7:0] status_byte(input logic ready, input logic del,
                                               input logic init_done);
        return {ready, del, 3'b000, init_done, 2'b00};
    endfunction

endpackage

// File: rtl/fdc_byte_store.sv
module fdc_byte_store #(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic                     load_en,
    input  logic [DEPTH*W-1:0]       load_data,
    output logic [DEPTH*W-1:0]       all_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (load_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= load_data[i*W +: W];
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign all_data[g*W +: W] = mem[g];
    end
endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
    import fdc_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int INIT_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_cmd,
    input  logic                     wr_buf,
    input  logic                     rd_buf,
    input  logic [15:0]              wdata,
    input  logic [1:0]               wp,
    input  logic [7:0]               silo_byte,
    output logic [$clog2(DEPTH)-1:0] idx,
    output logic                     silo_wr,
    output logic                     silo_load,
    output logic                     media_load,
    output logic [15:0]              cmd_rdata,
    output logic [7:0]               buf_rdata
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int ICW   = $clog2(INIT_CYCLES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DEPTH - 1);
    localparam logic [ICW-1:0]   LAST_INIT = ICW'(INIT_CYCLES - 1);

    fdc_state_e state;
    fdc_cmd_t   cmd;
    logic [ICW-1:0] icnt;
    logic [7:0] sec, trk, code, bufreg, fault;
    logic err, del, media_del, init_done, xfer, done, treq;

    logic unused_bits;
    assign unused_bits = ^{wdata[15], wdata[13:8]};

    assign done = (state == ST_IDLE);
    assign treq = (state == ST_SEC) || (state == ST_TRK) ||
                  (state == ST_FILL) || (state == ST_EMPTY);

    always_comb begin
        fault = '0;
        if (trk > MAX_TRACK)                          fault = ERR_TRACK;
        else if (sec == 8'd0 || sec > MAX_SECTOR)     fault = ERR_SECTOR;
        else if (cmd.fn != FN_READ && wp[cmd.unit])   fault = ERR_WPROT;
    end

    assign xfer = (state == ST_EXEC) &&
                  (cmd.fn == FN_READ || cmd.fn == FN_WRITE || cmd.fn == FN_WRDEL);
    assign silo_load  = xfer && (fault == 8'd0) && (cmd.fn == FN_READ);
    assign media_load = xfer && (fault == 8'd0) && (cmd.fn != FN_READ);
    assign silo_wr    = (state == ST_FILL) && wr_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  cmd <= '0;  idx <= '0;  icnt <= '0;
            sec <= '0;  trk <= '0;  code <= '0;  bufreg <= '0;
            err <= 1'b0;  del <= 1'b0;  media_del <= 1'b0;  init_done <= 1'b1;
        end else if (wr_cmd && wdata[14]) begin
            state <= ST_INIT;  icnt <= '0;  cmd.ie <= wdata[6];
            err <= 1'b0;  code <= '0;  del <= 1'b0;  init_done <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_buf) bufreg <= wdata[7:0];
                    if (wr_cmd) begin
                        cmd <= '{ie: wdata[6], unit: wdata[4], fn: fdc_fn_e'(wdata[3:1])};
                        if (wdata[0]) begin
                            err <= 1'b0;
                            idx <= '0;
                            case (fdc_fn_e'(wdata[3:1]))
                                FN_FILL:  begin state <= ST_FILL;  init_done <= 1'b0; end
                                FN_EMPTY: begin state <= ST_EMPTY; init_done <= 1'b0; end
                                FN_WRITE, FN_READ, FN_WRDEL:
                                          begin state <= ST_SEC;   init_done <= 1'b0; end
                                default:  state <= ST_EXEC;
                            endcase
                        end
                    end
                end
                ST_SEC: if (wr_buf) begin sec <= wdata[7:0]; state <= ST_TRK;  end
                ST_TRK: if (wr_buf) begin trk <= wdata[7:0]; state <= ST_EXEC; end
                ST_FILL: if (wr_buf) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) state <= ST_IDLE;
                end
                ST_EMPTY: if (rd_buf) begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) state <= ST_IDLE;
                end
                ST_EXEC: begin
                    state <= ST_IDLE;
                    case (cmd.fn)
                        FN_STATUS: bufreg <= status_byte(1'b1, del, init_done);
                        FN_ERRC:   bufreg <= code;
                        FN_READ, FN_WRITE, FN_WRDEL: begin
                            if (fault != 8'd0) begin
                                err  <= 1'b1;
                                code <= fault;
                            end else if (cmd.fn == FN_READ) begin
                                del <= media_del;
                            end else begin
                                media_del <= (cmd.fn == FN_WRDEL);
                            end
                        end
                        default: ;
                    endcase
                end
                ST_INIT: begin
                    icnt <= icnt + 1'b1;
                    if (icnt == LAST_INIT) begin
                        state     <= ST_IDLE;
                        init_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_rdata = {err, 1'b0, 6'b0, treq, cmd.ie, done, cmd.unit, cmd.fn, 1'b0};
    assign buf_rdata = (state == ST_EMPTY) ? silo_byte : bufreg;
endmodule

// File: rtl/fdc_cmd_if.sv
module fdc_cmd_if #(
    parameter int DEPTH       = 128,
    parameter int INIT_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_cmd,
    input  logic        wr_buf,
    input  logic        rd_buf,
    input  logic [15:0] wdata,
    input  logic [1:0]  wp,
    output logic [15:0] cmd_rdata,
    output logic [7:0]  buf_rdata,
    output logic        irq
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int W     = 8;

    logic [IDX_W-1:0]   idx;
    logic               silo_wr, silo_load, media_load;
    logic [DEPTH*W-1:0] silo_all, media_all;
    logic [W-1:0]       silo_byte;

    assign silo_byte = silo_all[idx*W +: W];

    fdc_seq #(.DEPTH(DEPTH), .INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_buf(wr_buf), .rd_buf(rd_buf),
        .wdata(wdata), .wp(wp), .silo_byte(silo_byte), .idx(idx),
        .silo_wr(silo_wr), .silo_load(silo_load), .media_load(media_load),
        .cmd_rdata(cmd_rdata), .buf_rdata(buf_rdata)
    );

    fdc_byte_store #(.DEPTH(DEPTH), .W(W)) u_silo (
        .clk(clk), .rst(rst), .wr_en(silo_wr), .wr_addr(idx), .wr_data(wdata[7:0]),
        .load_en(silo_load), .load_data(media_all), .all_data(silo_all)
    );

    fdc_byte_store #(.DEPTH(DEPTH), .W(W)) u_media (
        .clk(clk), .rst(rst), .wr_en(1'b0), .wr_addr('0), .wr_data('0),
        .load_en(media_load), .load_data(silo_all), .all_data(media_all)
    );

    assign irq = cmd_rdata[6] & cmd_rdata[5];
endmodule

// File: rtl/fdc_cmd_if_chk.sv
module fdc_cmd_if_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_cmd,
    input logic [15:0] wdata,
    input logic [15:0] cmd_rdata,
    input logic        irq
);
    AST_TREQ_EXCLUDES_DONE: assert property (@(posedge clk) disable iff (rst)
        !(cmd_rdata[7] && cmd_rdata[5])); // R3

    AST_ERR_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[15] |-> cmd_rdata[5]); // R4

    AST_INIT_ABORTS: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wdata[14]) |=> (!cmd_rdata[5] && !cmd_rdata[7] && !cmd_rdata[15])); // R10

    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && !wdata[14] && !cmd_rdata[5]) |=> $stable(cmd_rdata[4:1])); // R12

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cmd_rdata[5] && cmd_rdata[6])); // R13
endmodule

bind fdc_cmd_if fdc_cmd_if_chk u_chk (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wdata(wdata),
    .cmd_rdata(cmd_rdata), .irq(irq)
);

// File: tb/fdc_cmd_if_tb.sv
module fdc_cmd_if_tb;
    localparam int INIT_CYCLES = 8;
    localparam logic [2:0] F_FILL = 3'b000, F_EMPTY = 3'b001, F_WRITE = 3'b010,
                           F_READ = 3'b011, F_UNUSED = 3'b100, F_STATUS = 3'b101,
                           F_WRDEL = 3'b110, F_ERRC = 3'b111;

    logic clk = 1'b0, rst = 1'b1, wr_cmd = 1'b0, wr_buf = 1'b0, rd_buf = 1'b0;
    logic [15:0] wdata = '0;
    logic [1:0]  wp = '0;
    logic [15:0] cmd_rdata;
    logic [7:0]  buf_rdata;
    logic        irq;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fdc_cmd_if #(.INIT_CYCLES(INIT_CYCLES)) u_dut (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_buf(wr_buf), .rd_buf(rd_buf),
        .wdata(wdata), .wp(wp), .cmd_rdata(cmd_rdata), .buf_rdata(buf_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] go(input logic [2:0] fn, input logic unit);
        return {9'b0, 1'b0, 1'b0, unit, fn, 1'b1};
    endfunction

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * seed + 17) & 255);
    endfunction

    task automatic p_cmd(input logic [15:0] v);
        @(negedge clk); wdata = v; wr_cmd = 1'b1;
        @(negedge clk); wr_cmd = 1'b0;
    endtask

    task automatic p_buf(input logic [7:0] b);
        @(negedge clk); wdata = {8'h00, b}; wr_buf = 1'b1;
        @(negedge clk); wr_buf = 1'b0;
    endtask

    task automatic p_rd();
        @(negedge clk); rd_buf = 1'b1;
        @(negedge clk); rd_buf = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!cmd_rdata[5] && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic fill(input int seed);
        int bad = 0;
        p_cmd(go(F_FILL, 1'b0));
        for (int i = 0; i < 128; i++) begin
            if (!(cmd_rdata[7] && !cmd_rdata[5])) bad++;
            p_buf(pat(seed, i));
        end
        check(bad == 0, "R2 fill handshake", bad, 0);
        check(cmd_rdata[5] == 1'b1, "R2 done after fill", cmd_rdata[5], 1);
    endtask

    task automatic empty_cmp(input int seed, input string tag);
        int bad = 0, first_act = 0, first_exp = 0;
        p_cmd(go(F_EMPTY, 1'b0));
        for (int i = 0; i < 128; i++) begin
            if (!cmd_rdata[7] || buf_rdata != pat(seed, i)) begin
                if (bad == 0) begin first_act = buf_rdata; first_exp = pat(seed, i); end
                bad++;
            end
            p_rd();
        end
        check(bad == 0, tag, first_act, first_exp);
        check(cmd_rdata[5] == 1'b1, "R2 done after empty", cmd_rdata[5], 1);
    endtask

    task automatic sec_cmd(input logic [2:0] fn, input logic unit,
                           input logic [7:0] s, input logic [7:0] t);
        p_cmd(go(fn, unit)); p_buf(s); p_buf(t); wait_done();
    endtask

    task automatic rd_code(output int c);
        p_cmd(go(F_ERRC, 1'b0)); wait_done(); c = buf_rdata;
    endtask

    task automatic rd_status(output int s);
        p_cmd(go(F_STATUS, 1'b0)); wait_done(); s = buf_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, nbad, n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cmd_rdata[5] == 1'b1, "R1 done", cmd_rdata[5], 1);
        check(cmd_rdata[7] == 1'b0, "R1 treq", cmd_rdata[7], 0);
        check(cmd_rdata[15] == 1'b0, "R1 err", cmd_rdata[15], 0);
        check(irq == 1'b0 && buf_rdata == 8'd0, "R1 irq/buf", buf_rdata, 0);

        // R13 interrupt enable without start
        p_cmd(16'h0040);
        check(irq == 1'b1, "R13 irq on ie&done", irq, 1);
        p_cmd(16'h0000);
        check(irq == 1'b0, "R13 irq off", irq, 0);

        // R2 fill/empty round trip
        fill(3);
        empty_cmp(3, "R2 empty data");

        // R12 start while busy ignored
        p_cmd(go(F_FILL, 1'b0));
        p_buf(8'hAA);
        p_cmd(go(F_EMPTY, 1'b0));
        check(cmd_rdata[3:1] == F_FILL && cmd_rdata[7], "R12 busy write ignored",
              cmd_rdata[3:1], F_FILL);
        for (int i = 1; i < 128; i++) p_buf(8'hAA);
        check(cmd_rdata[5] == 1'b1, "R12 fill completes", cmd_rdata[5], 1);

        // R3 and R7: sector handshake, write then read back
        fill(5);
        p_cmd(go(F_WRITE, 1'b0));
        check(cmd_rdata[7] && !cmd_rdata[5], "R3 treq for sector", cmd_rdata[7], 1);
        p_buf(8'd5);
        check(cmd_rdata[7] && !cmd_rdata[5], "R3 treq for track", cmd_rdata[7], 1);
        p_buf(8'd10);
        wait_done();
        check(cmd_rdata[15] == 1'b0, "R3 write ok", cmd_rdata[15], 0);
        fill(11);
        sec_cmd(F_READ, 1'b0, 8'd5, 8'd10);
        empty_cmp(5, "R7 read returns written data");

        // R8 / R9 deleted mark in status
        rd_status(v);
        check(v == 8'h80, "R8 status after plain write", v, 8'h80);
        sec_cmd(F_WRDEL, 1'b0, 8'd1, 8'd0);
        sec_cmd(F_READ, 1'b0, 8'd1, 8'd0);
        rd_status(v);
        check(v == 8'hC0, "R8 R9 status after deleted write", v, 8'hC0);
        sec_cmd(F_WRITE, 1'b0, 8'd1, 8'd0);
        sec_cmd(F_READ, 1'b0, 8'd1, 8'd0);
        rd_status(v);
        check(v == 8'h80, "R8 deleted mark cleared", v, 8'h80);

        // R4 track sweep across the limit
        nbad = 0;
        for (int t = 60; t <= 90; t++) begin
            sec_cmd(F_READ, 1'b0, 8'd3, 8'(t));
            if (cmd_rdata[15] != (t > 76)) nbad++;
            if (t > 76) begin rd_code(v); if (v != 32'o40) nbad++; end
        end
        check(nbad == 0, "R4 track sweep", nbad, 0);
        sec_cmd(F_READ, 1'b0, 8'd0, 8'd80);
        rd_code(v);
        check(v == 32'o40, "R4 track before sector", v, 32'o40);

        // R5 sector sweep
        nbad = 0;
        for (int s = 0; s <= 30; s++) begin
            sec_cmd(F_READ, 1'b0, 8'(s), 8'd1);
            if (cmd_rdata[15] != (s == 0 || s > 26)) nbad++;
            if (s == 0 || s > 26) begin rd_code(v); if (v != 32'o70) nbad++; end
        end
        check(nbad == 0, "R5 sector sweep", nbad, 0);

        // R6 write protect per unit
        fill(7);
        sec_cmd(F_WRITE, 1'b0, 8'd2, 8'd2);
        fill(9);
        wp = 2'b10;
        sec_cmd(F_WRITE, 1'b0, 8'd2, 8'd2);
        check(cmd_rdata[15] == 1'b0, "R6 unit0 unprotected", cmd_rdata[15], 0);
        fill(13);
        sec_cmd(F_WRITE, 1'b1, 8'd2, 8'd2);
        check(cmd_rdata[15] == 1'b1, "R6 unit1 protected", cmd_rdata[15], 1);
        rd_code(v);
        check(v == 32'o100, "R6 code", v, 32'o100);
        wp = 2'b00;
        fill(3);
        sec_cmd(F_READ, 1'b0, 8'd2, 8'd2);
        empty_cmp(9, "R6 image unchanged");

        // R11 unused function
        rd_code(v);
        p_cmd(go(F_UNUSED, 1'b0));
        wait_done();
        check(buf_rdata == 8'(32'o100), "R11 buffer kept", buf_rdata, 32'o100);
        rd_code(v);
        check(v == 32'o100, "R11 code kept", v, 32'o100);

        // R10 initialise aborts and times out
        sec_cmd(F_READ, 1'b0, 8'd3, 8'd99);
        p_cmd(go(F_WRITE, 1'b0));
        p_buf(8'd4);
        p_cmd(16'h4000);
        check(!cmd_rdata[5] && !cmd_rdata[7] && !cmd_rdata[15], "R10 abort",
              cmd_rdata[5], 0);
        n = 0;
        while (!cmd_rdata[5] && n < 100) begin @(negedge clk); n++; end
        check(n == INIT_CYCLES, "R10 init cycles", n, INIT_CYCLES);
        rd_status(v);
        check(v == 32'o204, "R10 status after init", v, 32'o204);
        rd_code(v);
        check(v == 0, "R10 code cleared", v, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule